// File: doc/BRIEF.md
# Indirect Address/Data Register Bridge

This block is a small 64-bit register slave that opens a window onto a larger downstream register space. The host first writes a target offset into a pointer register. Each later access to the window register is then sent to the downstream register port at that offset as a full 8-byte read or write. Nothing from the window is stored in the bridge. Alongside the window the slave holds a status register with write-one-to-clear semantics. Hardware can also set its bits through a per-bit set input. The slave has two control slots that take writes and discard them, and it flags a write to any offset it does not decode.

Host accesses are 64 bits wide. The register index is the byte address with its three low bits dropped. A request is held on `req_valid` until the cycle in which `req_ready` is high, and the access completes in that cycle. Every access except a window read completes in the cycle it is presented. A window read is sequenced by a three-state machine: `ST_IDLE`, `ST_RD_WAIT` and `ST_RD_DONE`.
- **Launch** (`ST_IDLE` to `ST_RD_WAIT`): the machine issues the downstream read and drops `req_ready`.
- **Capture** (`ST_RD_WAIT` to `ST_RD_DONE`): when `dn_rvalid` arrives, the returned word is latched.
- **Deliver** (`ST_RD_DONE` to `ST_IDLE`): `req_ready` rises and the latched word is presented on `req_rdata`.

Register indices: 0 is the pointer, 1 is the window, 2 is the status register, 3 and 4 are the discard slots. Any other index is undecoded.

Top module: `ixb_bridge`

## Requirements
- R1: The register index is `req_addr >> 3`, so the three low byte-address bits have no effect on which register is accessed.
- R2: A write to index 0 stores only bits [11:0] of the written value. A read of index 0 returns that value with bits [63:12] zero, and `dn_addr` carries it from the next cycle on.
- R3: A read of index 1 issues one downstream read (`dn_req`=1, `dn_we`=0) at the latched offset. `req_ready` stays low until `dn_rvalid`. The read completes in the following cycle with the returned word on `req_rdata`.
- R4: A write to index 1 completes in the cycle it is presented. It issues exactly one downstream write (`dn_req`=1, `dn_we`=1) carrying the written value at the latched offset.
- R5: A write to index 2 clears every status bit that is 1 in the written value and leaves the other bits unchanged.
- R6: A 1 on bit n of `sts_set` sets status bit n at the next clock edge. When it arrives in the same cycle as a clear of that bit, the set wins.
- R7: Writes to indices 3 and 4 are accepted without error, store nothing (reads of them return zero), and cause no downstream access.
- R8: A write to any index above 4 raises `req_err` in its completing cycle and changes no register.
- R9: Reads of indices other than 1 return stored contents (zero for the discard slots and undecoded indices), complete at once and never raise `req_err`.
- R10: After reset the pointer and status registers read zero and the bridge is idle with `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_AW (8) | Host byte address |
| req_wdata | input | 64 | Host write data |
| req_ready | output | 1 | Request completes this cycle |
| req_rdata | output | 64 | Read data, valid when `req_ready` |
| req_err | output | 1 | Undecoded write in its completing cycle |
| sts_set | input | 64 | Per-bit hardware set of the status register |
| dn_req | output | 1 | Downstream access strobe |
| dn_we | output | 1 | Downstream access is a write |
| dn_addr | output | OFF_W (12) | Downstream register offset |
| dn_wdata | output | 64 | Downstream write data |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 64 | Downstream read data |

## Verification
A wrong pointer value shows up at once on `dn_addr` and on the next window access, which lands at the wrong downstream offset. A stuck or skipped read state shows within a few cycles: either `req_ready` never returns, which the watchdog catches, or a window read finishes before the downstream data exists and carries a stale word. Status corruption is visible on the next status read. An undecoded write that slips into a register shows on the read that follows it.

// File: rtl/ixb_pkg.sv
package ixb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_RD_DONE = 2'd2
    } ixb_state_e;

    typedef enum logic [2:0] {
        K_PTR  = 3'd0,
        K_WIN  = 3'd1,
        K_STAT = 3'd2,
        K_AUXA = 3'd3,
        K_AUXB = 3'd4,
        K_NONE = 3'd5
    } ixb_kind_e;

    localparam int unsigned IDX_PTR  = 0;
    localparam int unsigned IDX_WIN  = 1;
    localparam int unsigned IDX_STAT = 2;
    localparam int unsigned IDX_AUXA = 3;
    localparam int unsigned IDX_AUXB = 4;

endpackage

// File: rtl/ixb_decode.sv
module ixb_decode
    import ixb_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    output ixb_kind_e        kind
);
    always_comb begin
        unique case (32'(idx))
            IDX_PTR:  kind = K_PTR;
            IDX_WIN:  kind = K_WIN;
            IDX_STAT: kind = K_STAT;
            IDX_AUXA: kind = K_AUXA;
            IDX_AUXB: kind = K_AUXB;
            default:  kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/ixb_fsm.sv
module ixb_fsm
    import ixb_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_rd_req,
    input  logic          dn_rvalid,
    input  logic [DW-1:0] dn_rdata,
    output logic          host_ready,
    output logic          dn_rd_go,
    output logic [DW-1:0] hold_data,
    output ixb_state_e    state
);
    ixb_state_e nxt;
    logic       cap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt        = state;
        host_ready = 1'b0;
        dn_rd_go   = 1'b0;
        cap        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (win_rd_req) begin
                    dn_rd_go = 1'b1;
                    nxt      = ST_RD_WAIT;
                end else begin
                    host_ready = 1'b1;
                end
            end
            ST_RD_WAIT: begin
                if (dn_rvalid) begin
                    cap = 1'b1;
                    nxt = ST_RD_DONE;
                end
            end
            ST_RD_DONE: begin
                host_ready = 1'b1;
                nxt        = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hold_data <= '0;
        else if (cap) hold_data <= dn_rdata;
    end
endmodule

// File: rtl/ixb_regs.sv
module ixb_regs
    import ixb_pkg::*;
#(
    parameter int DW    = 64,
    parameter int OFF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  ixb_kind_e        kind,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    set_bits,
    output logic [OFF_W-1:0] ptr_q,
    output logic [DW-1:0]    sts_q,
    output logic             wr_err,
    output logic             win_wr
);
    logic [DW-1:0] clr_bits;

    assign clr_bits = (wr_fire && kind == K_STAT) ? wdata : '0;
    assign wr_err   = wr_fire && (kind == K_NONE);
    assign win_wr   = wr_fire && (kind == K_WIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        ptr_q <= '0;
        else if (wr_fire && kind == K_PTR) ptr_q <= wdata[OFF_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/ixb_bridge.sv
module ixb_bridge
    import ixb_pkg::*;
#(
    parameter int BUS_AW = 8,
    parameter int DW     = 64,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    output logic [DW-1:0]     req_rdata,
    output logic              req_err,
    input  logic [DW-1:0]     sts_set,
    output logic              dn_req,
    output logic              dn_we,
    output logic [OFF_W-1:0]  dn_addr,
    output logic [DW-1:0]     dn_wdata,
    input  logic              dn_rvalid,
    input  logic [DW-1:0]     dn_rdata
);
    localparam int LSB   = 3;
    localparam int IDX_W = BUS_AW - LSB;

    logic [IDX_W-1:0] idx;
    ixb_kind_e        kind;
    ixb_state_e       state;
    logic             win_rd_req, rd_go, wr_fire, win_wr, wr_err;
    logic [DW-1:0]    hold_data, sts_q;
    logic [OFF_W-1:0] ptr_q;

    assign idx        = req_addr[BUS_AW-1:LSB];
    assign win_rd_req = req_valid && !req_write && (kind == K_WIN);
    assign wr_fire    = req_valid && req_write && req_ready;

    ixb_decode #(.IDX_W(IDX_W)) u_dec (.idx(idx), .kind(kind));

    ixb_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .win_rd_req(win_rd_req),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata),
        .host_ready(req_ready), .dn_rd_go(rd_go),
        .hold_data(hold_data), .state(state)
    );

    ixb_regs #(.DW(DW), .OFF_W(OFF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .kind(kind),
        .wdata(req_wdata), .set_bits(sts_set), .ptr_q(ptr_q),
        .sts_q(sts_q), .wr_err(wr_err), .win_wr(win_wr)
    );

    assign dn_req   = rd_go || win_wr;
    assign dn_we    = win_wr;
    assign dn_addr  = ptr_q;
    assign dn_wdata = req_wdata;
    assign req_err  = wr_err;

    always_comb begin
        unique case (kind)
            K_PTR:   req_rdata = {{(DW-OFF_W){1'b0}}, ptr_q};
            K_WIN:   req_rdata = (state == ST_RD_DONE) ? hold_data : '0;
            K_STAT:  req_rdata = sts_q;
            default: req_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ixb_bridge_chk.sv
module ixb_bridge_chk #(
    parameter int BUS_AW = 8,
    parameter int DW     = 64,
    parameter int OFF_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [BUS_AW-1:0] req_addr,
    input logic [DW-1:0]     req_wdata,
    input logic              req_ready,
    input logic              req_err,
    input logic [DW-1:0]     sts_set,
    input logic [DW-1:0]     sts_q,
    input logic              dn_req,
    input logic              dn_we,
    input logic [OFF_W-1:0]  dn_addr,
    input logic              dn_rvalid
);
    logic ptr_wr;
    assign ptr_wr = req_valid && req_write && req_ready && (req_addr[BUS_AW-1:3] == '0);

    // R2
    ptr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> dn_addr == $past(req_wdata[OFF_W-1:0]));

    // R3
    rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_we) |=> !req_ready);

    // R3
    rd_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_rvalid && !req_ready) |=> req_ready);

    // R4
    wr_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_we) |-> (req_valid && req_write && req_ready));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & $past(sts_set)) == $past(sts_set)));

    // R8
    err_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_valid && req_write && req_ready && !dn_req));
endmodule

bind ixb_bridge ixb_bridge_chk #(.BUS_AW(BUS_AW), .DW(DW), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_err(req_err), .sts_set(sts_set), .sts_q(sts_q), .dn_req(dn_req),
    .dn_we(dn_we), .dn_addr(dn_addr), .dn_rvalid(dn_rvalid)
);

// File: tb/ixb_bridge_bench.sv
module ixb_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [63:0] req_wdata = '0, sts_set = '0;
    logic        req_ready, req_err, dn_req, dn_we;
    logic [63:0] req_rdata, dn_wdata;
    logic [11:0] dn_addr;
    logic        dn_rvalid = 1'b0;
    logic [63:0] dn_rdata = '0;

    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ixb_bridge u_ixb_bridge (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_rdata(req_rdata), .req_err(req_err), .sts_set(sts_set),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    // downstream device model
    logic [63:0] dn_mem [int unsigned];
    logic [11:0] pend_addr;
    int          wait_cnt = 0;
    int          dn_wr_cnt = 0, dn_rd_cnt = 0;
    logic [11:0] last_wr_addr;
    logic [63:0] last_wr_data;

    function automatic logic [63:0] dflt(input logic [11:0] a);
        return {52'hDEADBEEF00000, a};
    endfunction

    always @(posedge clk) begin
        dn_rvalid <= 1'b0;
        if (wait_cnt > 0) begin
            wait_cnt <= wait_cnt - 1;
            if (wait_cnt == 1) begin
                dn_rvalid <= 1'b1;
                dn_rdata  <= dn_mem.exists(32'(pend_addr)) ? dn_mem[32'(pend_addr)] : dflt(pend_addr);
            end
        end
        if (dn_req && dn_we) begin
            dn_mem[32'(dn_addr)] = dn_wdata;
            dn_wr_cnt++;
            last_wr_addr = dn_addr;
            last_wr_data = dn_wdata;
        end
        if (dn_req && !dn_we) begin
            pend_addr <= dn_addr;
            wait_cnt  <= 1 + int'($urandom % 4);
            dn_rd_cnt++;
        end
    end

    // expected model
    logic [63:0] ref_mem [int unsigned];
    logic [11:0] exp_ptr = '0;
    logic [63:0] exp_sts = '0;

    function automatic logic [63:0] ref_rd(input logic [11:0] a);
        return ref_mem.exists(32'(a)) ? ref_mem[32'(a)] : dflt(a);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [63:0] wd,
                          input logic [63:0] setv, output logic [63:0] rd,
                          output logic er, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; sts_set = setv;
        cyc = 1;
        forever begin
            #3;
            if (req_ready) begin
                rd = req_rdata; er = req_err;
                @(posedge clk);
                break;
            end
            @(posedge clk);
            sts_set = '0;
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; sts_set = '0;
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [63:0] wd, input logic [63:0] setv,
                         output logic er);
        logic [63:0] rd; int c;
        access(1'b1, a, wd, setv, rd, er, c);
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [63:0] rd, output int c);
        logic er;
        access(1'b0, a, '0, '0, rd, er, c);
        check("R9 no error on read", {63'd0, er}, 64'd0);
    endtask

    initial begin
        #(8*200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd; logic er; int c; int wc;
        process::self().srandom(32'h1234_5678);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10 reset state
        #3 check("R10 ready after reset", {63'd0, req_ready}, 64'd1);
        do_rd(8'h00, rd, c); check("R10 pointer reset", rd, 64'd0);
        do_rd(8'h10, rd, c); check("R10 status reset", rd, 64'd0);

        // R2 pointer keeps 12 bits
        do_wr(8'h00, 64'hFFFF_FFFF_FFFF_FABC, '0, er); exp_ptr = 12'hABC;
        do_rd(8'h00, rd, c); check("R2 pointer masked", rd, 64'hABC);
        check("R2 dn_addr follows", {52'd0, dn_addr}, 64'hABC);

        // R1 low address bits ignored
        do_wr(8'h05, 64'h123, '0, er); exp_ptr = 12'h123;
        do_rd(8'h07, rd, c); check("R1 low bits ignored", rd, 64'h123);

        // R4 window write forwarded
        wc = dn_wr_cnt;
        do_wr(8'h08, 64'h0102_0304_0506_0708, '0, er); ref_mem[32'h123] = 64'h0102_0304_0506_0708;
        check("R4 one downstream write", 64'(dn_wr_cnt - wc), 64'd1);
        check("R4 write offset", {52'd0, last_wr_addr}, 64'h123);
        check("R4 write data", last_wr_data, 64'h0102_0304_0506_0708);

        // R3 window read with stall
        do_rd(8'h08, rd, c);
        check("R3 window read data", rd, 64'h0102_0304_0506_0708);
        check("R3 stalled at least 3 cycles", {63'd0, c >= 3}, 64'd1);
        do_wr(8'h00, 64'h7FF, '0, er); exp_ptr = 12'h7FF;
        do_rd(8'h08, rd, c); check("R3 unwritten offset", rd, dflt(12'h7FF));

        // R6 set, R5 clear, set wins
        do_wr(8'h20, 64'h0, 64'hF0, er);
        do_rd(8'h10, rd, c); check("R6 hardware set", rd, 64'hF0);
        do_wr(8'h10, 64'h30, 64'h10, er);
        do_rd(8'h10, rd, c); check("R6 set wins over clear", rd, 64'hD0);
        do_wr(8'h10, 64'h40, '0, er); exp_sts = 64'h90;
        do_rd(8'h10, rd, c); check("R5 write one to clear", rd, 64'h90);

        // R7 discard slots
        wc = dn_wr_cnt;
        do_wr(8'h18, 64'hAAAA, '0, er); check("R7 no error slot A", {63'd0, er}, 64'd0);
        do_wr(8'h20, 64'h5555, '0, er); check("R7 no error slot B", {63'd0, er}, 64'd0);
        do_rd(8'h18, rd, c); check("R7 slot A reads zero", rd, 64'd0);
        do_rd(8'h20, rd, c); check("R7 slot B reads zero", rd, 64'd0);
        check("R7 no downstream access", 64'(dn_wr_cnt - wc), 64'd0);

        // R8 undecoded write
        do_wr(8'h28, 64'h0, '0, er); check("R8 error raised", {63'd0, er}, 64'd1);
        do_wr(8'hF8, 64'h0, '0, er); check("R8 error high index", {63'd0, er}, 64'd1);
        do_rd(8'h00, rd, c); check("R8 pointer unchanged", rd, 64'h7FF);
        do_rd(8'h10, rd, c); check("R8 status unchanged", rd, 64'h90);
        do_rd(8'h30, rd, c); check("R9 undecoded read zero", rd, 64'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] ix; logic [63:0] v; logic [2:0] lo; bit wr;
            ix = 3'($urandom % 7); lo = 3'($urandom); wr = $urandom % 2;
            v = {$urandom, $urandom};
            if (ix == 0) v[63:4] = (v[63:4] & 60'hF) | ($urandom % 2 ? 60'h0 : v[63:4]);
            if (wr) begin
                wc = dn_wr_cnt;
                do_wr({2'b00, ix, lo}, v, '0, er);
                check("R8 error flag", {63'd0, er}, {63'd0, ix > 4});
                case (ix)
                    0: exp_ptr = v[11:0];
                    1: begin
                        ref_mem[32'(exp_ptr)] = v;
                        check("R4 random offset", {52'd0, last_wr_addr}, {52'd0, exp_ptr});
                    end
                    2: exp_sts = exp_sts & ~v;
                    default: check("R7 random no write", 64'(dn_wr_cnt - wc), 64'd0);
                endcase
            end else begin
                do_rd({2'b00, ix, lo}, rd, c);
                case (ix)
                    0: check("R2 random pointer", rd, {52'd0, exp_ptr});
                    1: check("R3 random window", rd, ref_rd(exp_ptr));
                    2: check("R5 random status", rd, exp_sts);
                    default: check("R9 random zero", rd, 64'd0);
                endcase
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule